// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block carries out the memory-access group of a small 32-bit load/store instruction set. Each instruction arrives as a 4-bit opcode, three 4-bit operand nibbles and a 32-bit immediate. The block holds eight 32-bit general-purpose registers. From these it either writes a register directly or issues one word request on a simple synchronous memory port. A read on that port returns its data in the cycle after the request.

Five operations are supported: load of the immediate, load with a register base plus a scaled 4-bit offset, load with a register base plus a scaled index register, and the two matching stores. Load and store forms place their operands in different nibbles. The decoder maps each form onto one shared address adder, the register file read ports and the write port. A one-cycle `done` pulse reports that a register writeback or a memory write has finished. `busy` marks the cycles in which a new instruction is not taken.

Top module: `ldst_agu`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `mem_req` are low, and all eight registers read as zero.
- R2: Opcode 0 writes `op_imm` into the register named by `op_a` at the accepting edge. `done` is high in the following cycle, with no memory request and `busy` staying low.
- R3: Opcode 1 reads the word at r[`op_b`] + 4*`op_a` (offset taken as unsigned 0..15) and writes it into r[`op_c`].
- R4: Opcode 2 reads the word at r[`op_a`] + 4*r[`op_b`] and writes it into r[`op_c`].
- R5: Opcode 3 writes r[`op_a`] to address r[`op_c`] + 4*`op_b` (offset unsigned 0..15).
- R6: Opcode 4 writes r[`op_a`] to address r[`op_b`] + 4*r[`op_c`].
- R7: Load timing: if an instruction is accepted at edge T, `mem_req` is high with `mem_we` low in cycle T+1. `mem_rdata` is taken in cycle T+2, and `done` is high in cycle T+3. `busy` is high in cycles T+1 and T+2.
- R8: Store timing: `mem_req` and `mem_we` are high with address and data in cycle T+1. `done` is high in cycle T+2, and `busy` is high in cycle T+1 only.
- R9: Each load or store raises `mem_req` for exactly one cycle. Opcode 0 and unused opcodes never raise it, and `done` never coincides with `mem_req`.
- R10: Address arithmetic wraps modulo 2^32. The two low address bits come from the sum unchanged, so misaligned addresses pass through.
- R11: A register operand nibble selects a register by its low three bits. Bit 3 is ignored, so nibble 9 names r1.
- R12: An instruction presented while `busy` is high is dropped. It does not change any register or start any access.
- R13: Opcodes 5 to 15 are ignored. They cause no memory request, no `done` and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction present; taken when `busy` is low |
| op_code | input | 4 | Opcode nibble |
| op_a | input | 4 | First operand nibble (second nibble of the instruction) |
| op_b | input | 4 | Second operand nibble (third nibble) |
| op_c | input | 4 | Third operand nibble (fourth nibble) |
| op_imm | input | 32 | Immediate for opcode 0 |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |
| busy | output | 1 | A load or store is in progress |
| done | output | 1 | One-cycle pulse: writeback or memory write finished |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |

## Verification
The bench checks the operand role swap between load and store forms. A design that read the base from the wrong nibble would put out addresses that disagree with the reference model on the first store after a load. It drives offset and index values that overflow 32 bits, and a base with low bits set. A design that saturated or forced alignment would show a different `mem_addr`. Instructions held on `op_valid` during the busy cycles of a load, and unused opcodes, are followed by stores of the registers they could have changed. Any wrongly accepted write then shows up as bad `mem_wdata`. Operand nibbles with bit 3 set test register selection, and a design that decoded four bits would read a register outside the file.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam int XLEN     = 32;
    localparam int NREG     = 8;
    localparam int RIDX_W   = $clog2(NREG);
    localparam int NIB_W    = 4;
    localparam int SCALE_SH = 2;

    localparam logic [NIB_W-1:0] OPC_LD_IMM = 4'h0;
    localparam logic [NIB_W-1:0] OPC_LD_OFS = 4'h1;
    localparam logic [NIB_W-1:0] OPC_LD_IDX = 4'h2;
    localparam logic [NIB_W-1:0] OPC_ST_OFS = 4'h3;
    localparam logic [NIB_W-1:0] OPC_ST_IDX = 4'h4;

    typedef enum logic [1:0] {
        K_NONE,
        K_IMM,
        K_LOAD,
        K_STORE
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STORE,
        ST_LD_REQ,
        ST_LD_WAIT
    } state_e;

    typedef struct packed {
        kind_e             kind;
        logic              indexed;
        logic [RIDX_W-1:0] base_sel;
        logic [RIDX_W-1:0] idx_sel;
        logic [RIDX_W-1:0] data_sel;
        logic [RIDX_W-1:0] dest_sel;
        logic [NIB_W-1:0]  offset;
    } dec_t;

    function automatic logic [RIDX_W-1:0] reg_of(input logic [NIB_W-1:0] nib);
        return nib[RIDX_W-1:0];
    endfunction

    function automatic logic [XLEN-1:0] scale_word(input logic [XLEN-1:0] v);
        return v << SCALE_SH;
    endfunction

endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
    import ldst_pkg::*;
(
    input  logic [NIB_W-1:0] opcode,
    input  logic [NIB_W-1:0] nib_a,
    input  logic [NIB_W-1:0] nib_b,
    input  logic [NIB_W-1:0] nib_c,
    output dec_t             dec
);

    logic unused_hi;
    assign unused_hi = nib_c[NIB_W-1];

    always_comb begin
        dec = '0;
        dec.kind = K_NONE;
        unique case (opcode)
            OPC_LD_IMM: begin
                dec.kind     = K_IMM;
                dec.dest_sel = reg_of(nib_a);
            end
            OPC_LD_OFS: begin
                dec.kind     = K_LOAD;
                dec.offset   = nib_a;
                dec.base_sel = reg_of(nib_b);
                dec.dest_sel = reg_of(nib_c);
            end
            OPC_LD_IDX: begin
                dec.kind     = K_LOAD;
                dec.indexed  = 1'b1;
                dec.base_sel = reg_of(nib_a);
                dec.idx_sel  = reg_of(nib_b);
                dec.dest_sel = reg_of(nib_c);
            end
            OPC_ST_OFS: begin
                dec.kind     = K_STORE;
                dec.data_sel = reg_of(nib_a);
                dec.offset   = nib_b;
                dec.base_sel = reg_of(nib_c);
            end
            OPC_ST_IDX: begin
                dec.kind     = K_STORE;
                dec.indexed  = 1'b1;
                dec.data_sel = reg_of(nib_a);
                dec.base_sel = reg_of(nib_b);
                dec.idx_sel  = reg_of(nib_c);
            end
            default: dec.kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/ldst_regfile.sv
module ldst_regfile #(
    parameter int NREG   = 8,
    parameter int XLEN   = 32,
    localparam int RIDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_sel,
    input  logic [XLEN-1:0]   wr_val,
    input  logic [RIDX_W-1:0] rd_sel0,
    input  logic [RIDX_W-1:0] rd_sel1,
    input  logic [RIDX_W-1:0] rd_sel2,
    output logic [XLEN-1:0]   rd_val0,
    output logic [XLEN-1:0]   rd_val1,
    output logic [XLEN-1:0]   rd_val2
);

    logic [XLEN-1:0] regs [NREG];
    logic [NREG-1:0] hit;

    for (genvar g = 0; g < NREG; g++) begin : g_sel
        assign hit[g] = wr_en && (wr_sel == RIDX_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (hit[i]) begin
                regs[i] <= wr_val;
            end
        end
    end

    assign rd_val0 = regs[rd_sel0];
    assign rd_val1 = regs[rd_sel1];
    assign rd_val2 = regs[rd_sel2];

endmodule

// File: rtl/ldst_addr.sv
module ldst_addr
    import ldst_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int OW = NIB_W
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] index,
    input  logic [OW-1:0] offset,
    input  logic          indexed,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] disp;

    always_comb begin
        if (indexed) begin
            disp = scale_word(index);
        end else begin
            disp = scale_word({{(AW-OW){1'b0}}, offset});
        end
    end

    assign addr = base + disp;

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
    import ldst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [NIB_W-1:0] op_code,
    input  logic [NIB_W-1:0] op_a,
    input  logic [NIB_W-1:0] op_b,
    input  logic [NIB_W-1:0] op_c,
    input  logic [XLEN-1:0]  op_imm,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             busy,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata
);

    dec_t              dec;
    state_e            state;
    logic              accept;
    logic [XLEN-1:0]   base_val, idx_val, data_val, ea;
    logic              rf_we;
    logic [RIDX_W-1:0] rf_wsel, dest_q;
    logic [XLEN-1:0]   rf_wval;

    ldst_decode u_dec (
        .opcode (op_code),
        .nib_a  (op_a),
        .nib_b  (op_b),
        .nib_c  (op_c),
        .dec    (dec)
    );

    assign accept = op_valid && (state == ST_IDLE);

    // one write port shared by immediate loads and memory loads
    always_comb begin
        if (state == ST_LD_WAIT) begin
            rf_we   = 1'b1;
            rf_wsel = dest_q;
            rf_wval = mem_rdata;
        end else begin
            rf_we   = accept && (dec.kind == K_IMM);
            rf_wsel = dec.dest_sel;
            rf_wval = op_imm;
        end
    end

    ldst_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rf_we),
        .wr_sel  (rf_wsel),
        .wr_val  (rf_wval),
        .rd_sel0 (dec.base_sel),
        .rd_sel1 (dec.idx_sel),
        .rd_sel2 (dec.data_sel),
        .rd_val0 (base_val),
        .rd_val1 (idx_val),
        .rd_val2 (data_val)
    );

    ldst_addr #(.AW(XLEN), .OW(NIB_W)) u_addr (
        .base    (base_val),
        .index   (idx_val),
        .offset  (dec.offset),
        .indexed (dec.indexed),
        .addr    (ea)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            done      <= 1'b0;
            dest_q    <= '0;
        end else begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done    <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        unique case (dec.kind)
                            K_IMM: done <= 1'b1;
                            K_LOAD: begin
                                mem_req  <= 1'b1;
                                mem_addr <= ea;
                                dest_q   <= dec.dest_sel;
                                state    <= ST_LD_REQ;
                            end
                            K_STORE: begin
                                mem_req   <= 1'b1;
                                mem_we    <= 1'b1;
                                mem_addr  <= ea;
                                mem_wdata <= data_val;
                                state     <= ST_STORE;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_STORE: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                ST_LD_REQ: state <= ST_LD_WAIT;
                ST_LD_WAIT: begin
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    assert_req_single_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    assert_req_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    assert_done_apart_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_req);

    assert_store_done_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |=> (done && !busy));

    assert_load_done_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> (busy && !done) ##1 done);

endmodule

// File: tb/sim_ldst_agu.sv
module sim_ldst_agu;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0, op_a = '0, op_b = '0, op_c = '0;
    logic [31:0] op_imm = '0;
    logic [31:0] mem_rdata = '0;
    logic        busy, done, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;

    int    total = 0;
    int    bad = 0;
    bit    checking = 0;
    bit    finished = 0;
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    ldst_agu u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_imm(op_imm),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // behavioural memory: unwritten words return a pattern of their address
    logic [31:0] mem [logic [31:0]];

    function automatic logic [31:0] peek(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'h5A5A_A5A5;
    endfunction

    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr] = mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= peek(mem_addr);
    end

    // reference model, one step per clock
    logic [31:0] mr [8];
    int          ph = 0;
    int          ld_dst = 0;
    logic        e_req = 0, e_we = 0, e_done = 0;
    logic [31:0] e_addr = 0, e_wdata = 0, ld_val = 0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) mr[i] = 0;
            ph = 0; e_req = 0; e_we = 0; e_done = 0;
        end else begin
            e_done = 0;
            case (ph)
                0: begin
                    e_req = 0;
                    if (op_valid) begin
                        case (op_code)
                            4'h0: begin mr[op_a[2:0]] = op_imm; e_done = 1; end
                            4'h1: begin
                                e_addr = mr[op_b[2:0]] + {28'd0, op_a} * 4;
                                ld_dst = int'(op_c[2:0]); e_req = 1; e_we = 0; ph = 1;
                            end
                            4'h2: begin
                                e_addr = mr[op_a[2:0]] + mr[op_b[2:0]] * 4;
                                ld_dst = int'(op_c[2:0]); e_req = 1; e_we = 0; ph = 1;
                            end
                            4'h3: begin
                                e_addr = mr[op_c[2:0]] + {28'd0, op_b} * 4;
                                e_wdata = mr[op_a[2:0]]; e_req = 1; e_we = 1; ph = 3;
                            end
                            4'h4: begin
                                e_addr = mr[op_b[2:0]] + mr[op_c[2:0]] * 4;
                                e_wdata = mr[op_a[2:0]]; e_req = 1; e_we = 1; ph = 3;
                            end
                            default: ;
                        endcase
                    end
                end
                1: begin e_req = 0; ld_val = peek(e_addr); ph = 2; end
                2: begin mr[ld_dst] = ld_val; e_done = 1; ph = 0; end
                default: begin e_req = 0; e_done = 1; ph = 0; end
            endcase
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (checking && !rst) begin
            chk(32'(mem_req), 32'(e_req), "mem_req");
            if (e_req) begin
                chk(32'(mem_we), 32'(e_we), "mem_we");
                chk(mem_addr, e_addr, "mem_addr");
                if (e_we) chk(mem_wdata, e_wdata, "mem_wdata");
            end
            chk(32'(done), 32'(e_done), "done");
            chk(32'(busy), 32'(ph != 0), "busy");
        end
    end

    task automatic send(input logic [3:0] oc, input logic [3:0] a, input logic [3:0] b,
                        input logic [3:0] c, input logic [31:0] imm);
        @(negedge clk);
        op_valid = 1; op_code = oc; op_a = a; op_b = b; op_c = c; op_imm = imm;
        @(negedge clk);
        op_valid = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL %s watchdog actual=running expected=finished", cur_tag);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state at the ports
        cur_tag = "R1";
        chk(32'(busy), 0, "busy after reset");
        chk(32'(done), 0, "done after reset");
        chk(32'(mem_req), 0, "mem_req after reset");
        checking = 1;
        send(4'h3, 4'd5, 4'd0, 4'd0, 0);       // r5 -> m[r0]: zero data, zero address
        send(4'h4, 4'd7, 4'd6, 4'd3, 0);       // r7 -> m[r6+4*r3]

        cur_tag = "R2";
        send(4'h0, 4'd1, 4'd0, 4'd0, 32'h0000_1000);
        send(4'h0, 4'd2, 4'd0, 4'd0, 32'h0000_2000);
        send(4'h0, 4'd3, 4'd0, 4'd0, 32'h0000_0003);
        send(4'h0, 4'd4, 4'd0, 4'd0, 32'hFFFF_FFF0);

        cur_tag = "R5";
        send(4'h3, 4'd1, 4'd5, 4'd2, 0);       // m[0x2014] = 0x1000
        cur_tag = "R6";
        send(4'h4, 4'd2, 4'd1, 4'd3, 0);       // m[0x100C] = 0x2000

        cur_tag = "R3";
        send(4'h1, 4'd5, 4'd2, 4'd6, 0);       // r6 = m[0x2014]
        send(4'h3, 4'd6, 4'd0, 4'd0, 0);       // show r6
        cur_tag = "R4";
        send(4'h2, 4'd1, 4'd3, 4'd7, 0);       // r7 = m[0x100C]
        send(4'h3, 4'd7, 4'd1, 4'd0, 0);       // show r7

        cur_tag = "R7";
        send(4'h1, 4'd0, 4'd2, 4'd5, 0);       // unwritten word at 0x2000
        send(4'h4, 4'd5, 4'd0, 4'd0, 0);
        cur_tag = "R8";
        send(4'h3, 4'd3, 4'd15, 4'd1, 0);      // largest offset

        cur_tag = "R10";
        send(4'h1, 4'd15, 4'd4, 4'd5, 0);      // 0xFFFFFFF0 + 60 wraps to 0x2C
        send(4'h0, 4'd7, 4'd0, 4'd0, 32'h4000_0005);
        send(4'h2, 4'd1, 4'd7, 4'd2, 0);       // 4*r7 wraps: address 0x1014
        send(4'h0, 4'd5, 4'd0, 4'd0, 32'h0000_1001);
        send(4'h3, 4'd2, 4'd1, 4'd5, 0);       // misaligned 0x1005
        send(4'h1, 4'd1, 4'd5, 4'd6, 0);       // read back from 0x1005

        cur_tag = "R11";
        send(4'h0, 4'd9, 4'd0, 4'd0, 32'h0000_ABCD);  // lands in r1
        send(4'h3, 4'd9, 4'd0, 4'd8, 0);
        send(4'h4, 4'd14, 4'd10, 4'd11, 0);

        cur_tag = "R12";
        @(negedge clk);
        op_valid = 1; op_code = 4'h1; op_a = 4'd0; op_b = 4'd0; op_c = 4'd6; op_imm = 0;
        @(negedge clk);
        op_code = 4'h0; op_a = 4'd6; op_imm = 32'hDEAD_BEEF;
        @(negedge clk);
        @(negedge clk);
        op_valid = 0;
        repeat (3) @(negedge clk);
        send(4'h3, 4'd6, 4'd0, 4'd0, 0);
        @(negedge clk);
        op_valid = 1; op_code = 4'h3; op_a = 4'd1; op_b = 4'd2; op_c = 4'd0; op_imm = 0;
        @(negedge clk);
        op_code = 4'h0; op_a = 4'd1; op_imm = 32'h1234_5678;
        @(negedge clk);
        op_valid = 0;
        repeat (3) @(negedge clk);
        send(4'h3, 4'd1, 4'd0, 4'd0, 0);

        cur_tag = "R13";
        for (int k = 5; k < 16; k++) send(4'(k), 4'd1, 4'd2, 4'd3, 32'hFFFF_0000);
        send(4'h3, 4'd1, 4'd0, 4'd0, 0);
        send(4'h3, 4'd2, 4'd0, 4'd0, 0);

        cur_tag = "R9";
        send(4'h2, 4'd2, 4'd3, 4'd4, 0);
        send(4'h4, 4'd4, 4'd2, 4'd3, 0);
        send(4'h0, 4'd3, 4'd0, 4'd0, 32'h0000_0010);

        checking = 0;
        finished = 1;
        summary();
        $finish;
    end

endmodule